// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Timer

This block times how long a switching controller spends in cycle-by-cycle current limiting and enforces a long, safe restart interval once that time runs out. A digital accumulator stands in for the charge on a timing capacitor. Every clock in which the current-limit flag is high adds a large step. When the sum reaches a programmed shutdown level, all four gate drives are forced low and soft start is discharged.

The accumulator then drains by a small step each clock down to a programmed low level. That makes the restart wait about a hundred times the shutdown delay. Only after the wait ends are the gate drives released, so a fresh soft start can begin.

An external overvoltage or overtemperature comparator flag shares the same restart path. While the flag is high, the outputs are off immediately. When it clears, the full restart wait runs from the top level before the outputs are released. Between current-limit hits during normal running, the accumulator either decays or holds, chosen by a parameter. With decay selected, isolated hits never trip.

Top module: `hiccup_fault_timer`

## Requirements
- R1: During reset and immediately after its release, `gate_off` and `ss_discharge` are 0 and `status` is 2'b00 (normal).
- R2: A single current-limit hit from the empty state sets `status` to 2'b01 (limiting) at the next clock edge, and the outputs stay permitted (`gate_off` = 0).
- R3: With default parameters, 12 consecutive hit clocks from empty (shutdown level 2400, up step 200) assert `gate_off` and `ss_discharge` and set `status` to 2'b10 after the 12th edge. After 11 such clocks, the outputs are still permitted.
- R4: In decay mode, each clock without a hit lowers the accumulator by the decay step (200 by default), with a floor at zero. `status` returns to 2'b00 once the accumulator is empty, and hits alternating with idle clocks never trip.
- R5: In hold mode, clocks without a hit keep the accumulator unchanged. `status` stays 2'b01, and hits later add to the held value.
- R6: After a trip, `gate_off` and `ss_discharge` stay high for exactly (2400 − 300) / 2 = 1050 clocks, with drain step 2 and low level 300. Then they fall, `status` returns to 2'b00 and the accumulator is empty, so 11 further hits do not trip.
- R7: Current-limit hits during the restart wait have no effect, and the wait length stays 1050 clocks.
- R8: `fault_in` high forces `gate_off` and `ss_discharge` high in the same cycle, without waiting for a clock edge. `status` reads 2'b10 from the next edge.
- R9: When `fault_in` clears, the outputs stay off for one more edge and then for the full 1050-clock restart wait, 1051 edges in all.
- R10: A fault arriving during the restart wait returns the block to the fault state, and a complete wait follows the clearing of that fault.
- R11: `status` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; one accumulation step per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ilim_hit | input | 1 | High in a clock in which current limiting cut the pulse |
| fault_in | input | 1 | External overvoltage/overtemperature comparator flag |
| gate_off | output | 1 | Request to hold all four gate drives low |
| ss_discharge | output | 1 | Request to discharge the soft-start capacitor |
| status | output | 2 | 00 normal, 01 limiting, 10 outputs off (fault or restart wait) |

## Verification
The checker assumes that `ilim_hit` and `fault_in` are synchronous to `clk` and settle between edges. It also assumes that the default step and level values hold, because its minimum-wait bound is derived from them. The bench drives both flags only at falling edges and samples one time unit after rising edges. The one check of the immediate fault path is made between edges, after the flag has settled. Fault pulses in the stimulus always span at least one full clock, so every fault state is visible at an edge.

// File: rtl/hiccup_pkg.sv
// Package: shared types for the hiccup fault timer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package hiccup_pkg;

    // Controller state of the timer
    typedef enum logic [1:0] {
        FS_NORMAL = 2'd0,
        FS_LIMIT  = 2'd1,
        FS_WAIT   = 2'd2,
        FS_FAULT  = 2'd3
    } hic_state_e;

    // Command from the state machine to the accumulator
    typedef enum logic [2:0] {
        AC_HOLD   = 3'd0,
        AC_CLEAR  = 3'd1,
        AC_CHARGE = 3'd2,
        AC_DECAY  = 3'd3,
        AC_DRAIN  = 3'd4,
        AC_TOP    = 3'd5
    } acc_cmd_e;

    // Externally visible status code
    localparam logic [1:0] ST_NORMAL = 2'b00;
    localparam logic [1:0] ST_LIMIT  = 2'b01;
    localparam logic [1:0] ST_OFF    = 2'b10;

endpackage

// File: rtl/hiccup_accum.sv
// Module: hiccup_accum
// Digital stand-in for the timing capacitor. It charges by UP_STEP, decays by
// DECAY_STEP (or holds), drains by DRAIN_STEP and loads the top level on command.
// It reports, from the present value, whether the next charge trips, whether the
// next decay empties and whether the next drain ends the restart wait.
// Assumes: TRIP_LEVEL fits in ACC_W bits and RESTART_LEVEL + DRAIN_STEP < TRIP_LEVEL.
module hiccup_accum
    import hiccup_pkg::*;
#(
    parameter int ACC_W         = 12,
    parameter int UP_STEP       = 200,
    parameter int DRAIN_STEP    = 2,
    parameter int DECAY_STEP    = 200,
    parameter bit DECAY_EN      = 1'b1,
    parameter int TRIP_LEVEL    = 2400,
    parameter int RESTART_LEVEL = 300
) (
    input  logic     clk,
    input  logic     rst_n,
    input  acc_cmd_e cmd,
    output logic     will_trip,
    output logic     will_empty,
    output logic     will_restart
);

    localparam int SUM_W = ACC_W + 1;
    localparam logic [SUM_W-1:0] UP_V    = SUM_W'(UP_STEP);
    localparam logic [SUM_W-1:0] DRAIN_V = SUM_W'(DRAIN_STEP);
    localparam logic [SUM_W-1:0] DECAY_V = SUM_W'(DECAY_STEP);
    localparam logic [SUM_W-1:0] TRIP_V  = SUM_W'(TRIP_LEVEL);
    localparam logic [SUM_W-1:0] LOW_V   = SUM_W'(RESTART_LEVEL);
    localparam logic [SUM_W-1:0] EXIT_V  = LOW_V + DRAIN_V;

    logic [ACC_W-1:0] acc_q;
    logic [SUM_W-1:0] acc_ext;
    logic [ACC_W-1:0] acc_decayed;

    assign acc_ext = {1'b0, acc_q};

    // Trip and restart look-ahead from the present value
    always_comb begin
        will_trip    = (acc_ext + UP_V) >= TRIP_V;
        will_restart = acc_ext <= EXIT_V;
    end

    // Idle-cycle behaviour chosen by parameter: decay toward zero or hold
    generate
        if (DECAY_EN) begin : g_decay
            always_comb begin
                will_empty  = acc_ext <= DECAY_V;
                acc_decayed = will_empty ? '0 : (acc_q - DECAY_V[ACC_W-1:0]);
            end
        end else begin : g_hold
            always_comb begin
                will_empty  = (acc_q == '0);
                acc_decayed = acc_q;
            end
        end
    endgenerate

    // Accumulator register updated by the command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            case (cmd)
                AC_CLEAR:  acc_q <= '0;
                AC_CHARGE: acc_q <= acc_q + UP_V[ACC_W-1:0];
                AC_DECAY:  acc_q <= acc_decayed;
                AC_DRAIN:  acc_q <= acc_q - DRAIN_V[ACC_W-1:0];
                AC_TOP:    acc_q <= TRIP_V[ACC_W-1:0];
                default:   acc_q <= acc_q;
            endcase
        end
    end

endmodule

// File: rtl/hiccup_ctrl.sv
// Module: hiccup_ctrl
// State machine of the timer. It walks through normal, limiting, restart wait
// and external fault, and it issues one accumulator command per clock.
// Assumes: the look-ahead flags describe the accumulator value of this cycle.
module hiccup_ctrl
    import hiccup_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ilim_hit,
    input  logic       fault_in,
    input  logic       will_trip,
    input  logic       will_empty,
    input  logic       will_restart,
    output acc_cmd_e   cmd,
    output hic_state_e state
);

    hic_state_e state_q;
    hic_state_e state_d;

    assign state = state_q;

    // Next state and accumulator command
    always_comb begin
        state_d = state_q;
        cmd     = AC_HOLD;
        case (state_q)
            FS_NORMAL, FS_LIMIT: begin
                if (fault_in) begin
                    state_d = FS_FAULT;
                    cmd     = AC_TOP;
                end else if (ilim_hit) begin
                    if (will_trip) begin
                        state_d = FS_WAIT;
                        cmd     = AC_TOP;
                    end else begin
                        state_d = FS_LIMIT;
                        cmd     = AC_CHARGE;
                    end
                end else begin
                    cmd     = AC_DECAY;
                    state_d = will_empty ? FS_NORMAL : FS_LIMIT;
                end
            end
            FS_WAIT: begin
                if (fault_in) begin
                    state_d = FS_FAULT;
                    cmd     = AC_TOP;
                end else if (will_restart) begin
                    state_d = FS_NORMAL;
                    cmd     = AC_CLEAR;
                end else begin
                    cmd     = AC_DRAIN;
                end
            end
            default: begin
                cmd = AC_TOP;
                if (!fault_in) begin
                    state_d = FS_WAIT;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_NORMAL;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/hiccup_outmap.sv
// Module: hiccup_outmap
// Maps the timer state and the raw fault flag to the shutdown requests and the
// status code. The fault flag bypasses the state so that shutdown is immediate.
// Assumes: fault_in is synchronous to the clock domain of the state.
module hiccup_outmap
    import hiccup_pkg::*;
(
    input  hic_state_e state,
    input  logic       fault_in,
    output logic       gate_off,
    output logic       ss_discharge,
    output logic [1:0] status
);

    logic held_off;

    // Shutdown requests: state-held off, or a live fault
    always_comb begin
        held_off     = (state == FS_WAIT) || (state == FS_FAULT);
        gate_off     = held_off || fault_in;
        ss_discharge = held_off || fault_in;
    end

    // Status code from the registered state
    always_comb begin
        case (state)
            FS_NORMAL: status = ST_NORMAL;
            FS_LIMIT:  status = ST_LIMIT;
            default:   status = ST_OFF;
        endcase
    end

endmodule

// File: rtl/hiccup_fault_timer.sv
// Module: hiccup_fault_timer (top)
// Overcurrent hiccup timer. Current-limit hits charge an accumulator fast. At
// the trip level the gate drives are forced off and the accumulator drains
// slowly to the restart level. An external fault shares the same restart wait.
// Assumes: ilim_hit and fault_in are synchronous to clk.
module hiccup_fault_timer
    import hiccup_pkg::*;
#(
    parameter int ACC_W         = 12,
    parameter int UP_STEP       = 200,
    parameter int DRAIN_STEP    = 2,
    parameter int DECAY_STEP    = 200,
    parameter bit DECAY_EN      = 1'b1,
    parameter int TRIP_LEVEL    = 2400,
    parameter int RESTART_LEVEL = 300
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ilim_hit,
    input  logic       fault_in,
    output logic       gate_off,
    output logic       ss_discharge,
    output logic [1:0] status
);

    acc_cmd_e   cmd;
    hic_state_e state;
    logic       will_trip;
    logic       will_empty;
    logic       will_restart;

    hiccup_accum #(
        .ACC_W         (ACC_W),
        .UP_STEP       (UP_STEP),
        .DRAIN_STEP    (DRAIN_STEP),
        .DECAY_STEP    (DECAY_STEP),
        .DECAY_EN      (DECAY_EN),
        .TRIP_LEVEL    (TRIP_LEVEL),
        .RESTART_LEVEL (RESTART_LEVEL)
    ) accum_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd          (cmd),
        .will_trip    (will_trip),
        .will_empty   (will_empty),
        .will_restart (will_restart)
    );

    hiccup_ctrl ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ilim_hit     (ilim_hit),
        .fault_in     (fault_in),
        .will_trip    (will_trip),
        .will_empty   (will_empty),
        .will_restart (will_restart),
        .cmd          (cmd),
        .state        (state)
    );

    hiccup_outmap outmap_i (
        .state        (state),
        .fault_in     (fault_in),
        .gate_off     (gate_off),
        .ss_discharge (ss_discharge),
        .status       (status)
    );

endmodule

// File: rtl/hiccup_fault_timer_chk.sv
// Module: hiccup_fault_timer_chk
// Port-level checker bound to hiccup_fault_timer. It counts restart-wait length
// with a local counter, so no long $past window is needed.
// Assumes: the flags are synchronous to clk.
module hiccup_fault_timer_chk #(
    parameter int TRIP_LEVEL    = 2400,
    parameter int RESTART_LEVEL = 300,
    parameter int DRAIN_STEP    = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ilim_hit,
    input logic       fault_in,
    input logic       gate_off,
    input logic       ss_discharge,
    input logic [1:0] status
);

    localparam int WAIT_MIN = (TRIP_LEVEL - RESTART_LEVEL) / DRAIN_STEP - 1;

    int unsigned off_cnt;

    // Count consecutive sampled clocks in the off status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_cnt <= 0;
        end else if (status == 2'b10) begin
            off_cnt <= off_cnt + 1;
        end else begin
            off_cnt <= 0;
        end
    end

    assert_status_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);

    assert_fault_forces_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_in |-> (gate_off && ss_discharge));

    assert_off_status_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10) |-> (gate_off && ss_discharge));

    assert_limit_permits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b01 && !fault_in) |-> !gate_off);

    assert_trip_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status) != 2'b10 && status == 2'b10 && !$past(fault_in)) |-> $past(ilim_hit));

    assert_wait_min_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status) == 2'b10 && status == 2'b00) |-> (off_cnt >= WAIT_MIN));

endmodule

bind hiccup_fault_timer hiccup_fault_timer_chk #(
    .TRIP_LEVEL    (TRIP_LEVEL),
    .RESTART_LEVEL (RESTART_LEVEL),
    .DRAIN_STEP    (DRAIN_STEP)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ilim_hit     (ilim_hit),
    .fault_in     (fault_in),
    .gate_off     (gate_off),
    .ss_discharge (ss_discharge),
    .status       (status)
);

// File: tb/hiccup_fault_timer_tb_top.sv
// Bench for hiccup_fault_timer: a vector table walk, then directed tests.
module hiccup_fault_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LEN   = 1050;
    localparam int NVEC       = 10;

    // Vector format: {hit, fault, exp_off, exp_status[1:0]}
    localparam logic [4:0] VEC [NVEC] = '{
        5'b10_0_01, 5'b00_0_00, 5'b10_0_01, 5'b10_0_01, 5'b00_0_01,
        5'b00_0_00, 5'b00_0_00, 5'b01_1_10, 5'b11_1_10, 5'b00_1_10
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ilim_hit = 1'b0;
    logic       fault_in = 1'b0;
    logic       gate_off, ss_discharge;
    logic [1:0] status;
    logic       hold_off, hold_ss;
    logic [1:0] hold_status;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hiccup_fault_timer dut_i (
        .clk(clk), .rst_n(rst_n), .ilim_hit(ilim_hit), .fault_in(fault_in),
        .gate_off(gate_off), .ss_discharge(ss_discharge), .status(status)
    );

    hiccup_fault_timer #(.DECAY_EN(1'b0)) dut_hold_i (
        .clk(clk), .rst_n(rst_n), .ilim_hit(ilim_hit), .fault_in(fault_in),
        .gate_off(hold_off), .ss_discharge(hold_ss), .status(hold_status)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic hit, input logic flt);
        @(negedge clk);
        ilim_hit = hit;
        fault_in = flt;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ilim_hit = 1'b0; fault_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic count_off(output int n);
        n = 0;
        while (gate_off && n < 5000) begin
            @(posedge clk);
            #1;
            n++;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        int n;
        logic seen_off;
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        chk("R1 off in reset", gate_off, 0);
        chk("R1 ss in reset", ss_discharge, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 status after reset", status, 0);

        // Table walk: R2 R4 R8 short patterns
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][4], VEC[i][3]);
            chk("R2/R4/R8 vector off", gate_off, VEC[i][2]);
            chk("R2/R4/R8 vector status", status, VEC[i][1:0]);
        end

        // R3: 11 hits keep running, 12th trips
        do_reset();
        for (int i = 0; i < 11; i++) step(1'b1, 1'b0);
        chk("R3 no trip after 11", gate_off, 0);
        step(1'b1, 1'b0);
        chk("R3 trip off after 12", gate_off, 1);
        chk("R3 trip ss after 12", ss_discharge, 1);
        chk("R3 trip status", status, 2);
        // R6: restart wait length and clean restart
        @(negedge clk);
        ilim_hit = 1'b0;
        count_off(n);
        chk("R6 wait length", n, WAIT_LEN);
        chk("R6 status after wait", status, 0);
        for (int i = 0; i < 11; i++) step(1'b1, 1'b0);
        chk("R6 accumulator cleared", gate_off, 0);

        // R7: hits during the wait are ignored
        do_reset();
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
        count_off(n);
        chk("R7 wait length with hits", n, WAIT_LEN);

        // R4: alternating hits never trip
        do_reset();
        seen_off = 1'b0;
        for (int i = 0; i < 60; i++) begin
            step(i[0] == 1'b0, 1'b0);
            seen_off |= gate_off;
        end
        chk("R4 alternation no trip", seen_off, 0);

        // R5: hold mode keeps the value; decay mode empties
        do_reset();
        step(1'b1, 1'b0);
        for (int i = 0; i < 50; i++) step(1'b0, 1'b0);
        chk("R5 hold status limiting", hold_status, 1);
        chk("R4 decay status normal", status, 0);
        for (int i = 0; i < 11; i++) step(1'b1, 1'b0);
        chk("R5 hold accumulates to trip", hold_off, 1);
        chk("R4 decay no trip", gate_off, 0);

        // R8: immediate shutdown on fault
        do_reset();
        step(1'b0, 1'b0);
        @(negedge clk);
        fault_in = 1'b1;
        #1;
        chk("R8 immediate off", gate_off, 1);
        chk("R8 immediate ss", ss_discharge, 1);
        chk("R8 status before edge", status, 0);
        @(posedge clk);
        #1;
        chk("R8 status after edge", status, 2);
        step(1'b0, 1'b1);
        // R9: wait after fault clears
        @(negedge clk);
        fault_in = 1'b0;
        count_off(n);
        chk("R9 fault wait length", n, WAIT_LEN + 1);

        // R10: fault during the wait restarts it
        do_reset();
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        for (int i = 0; i < 100; i++) step(1'b0, 1'b0);
        chk("R10 still off mid wait", gate_off, 1);
        step(1'b0, 1'b1);
        @(negedge clk);
        fault_in = 1'b0;
        count_off(n);
        chk("R10 full wait after refault", n, WAIT_LEN + 1);
        chk("R11 status legal", status, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule